// File: doc/BRIEF.md
# Type-0 Configuration Address Translator

This block sits behind a CPU-visible configuration window and turns each access into a standard configuration address. The caller supplies four things. The first is the low 16 bits of the CPU offset into the window. The second is a 32-bit mapping register whose low half becomes the upper half of a composed address. The third is a two-bit access size code, and the fourth is the number of the target bus. Inside the composed address, the device-select field is one-hot, and the device number is recovered by finding its lowest set bit. The function number and the register offset are copied through unchanged. The bus number is placed above them, and the enable bit is set at the top.

A request that cannot be translated is flagged as an error. There are two such cases: the mapping register asks for a type-1 request, or no device-select bit is set. On an erroneous read, the block supplies all-ones fill data of the access width. On an erroneous write, the block drops the write. On every good access it pulses a strobe that clears the received-master-abort and received-target-abort bits of the bridge status. Translation is combinational. All results are registered together and presented one cycle after the request, alongside a response valid.

Top module: `cfgx_translator`

## Requirements
- R1: The device-select field is {mapCfg[15:0], cpuOffset[15:11]} (21 bits). The device number is the index of its lowest set bit, counted from cpuOffset[11] as index 0.
- R2: The function number is cpuOffset[10:8]. The register offset is cpuOffset[7:2]. cfgAddr[1:0] is always 0.
- R3: A good response gives cfgAddr = bit31 set, bits 30:24 zero, busNum in 23:16, device in 15:11, function in 10:8, and register offset in 7:2.
- R4: mapCfg[16] set (type-1 request) gives respErr = 1 and cfgAddr = 0, whatever the other fields hold. mapCfg[31:17] have no effect.
- R5: A device-select field of all zeros gives respErr = 1 and cfgAddr = 0.
- R6: An erroneous read gives readFill with the low (sizeCode+1)*8 bits set and the rest clear. sizeCode 0..3 means 1..4 bytes. For any other response, readFill is 0.
- R7: An erroneous write is dropped: cfgWrEn stays low. An erroneous read raises neither cfgRdEn nor cfgWrEn.
- R8: A good write pulses cfgWrEn, and a good read pulses cfgRdEn. Each pulse lasts the one cycle of its response.
- R9: statusClr pulses with every good response and never with an erroneous one.
- R10: Each request sampled with reqValid gives exactly one respValid cycle on the next cycle. Back-to-back requests give back-to-back responses. In cycles without a response, every output is 0.
- R11: While rstN is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | A configuration access is presented this cycle |
| reqWrite | input | 1 | 1 for write, 0 for read |
| cpuOffset | input | 16 | Low bits of the CPU offset into the window |
| mapCfg | input | 32 | Mapping register; [15:0] upper address half, [16] type-1 request |
| sizeCode | input | 2 | Access size minus one, in bytes |
| busNum | input | 8 | Target bus number |
| respValid | output | 1 | Registered result present |
| respErr | output | 1 | Translation failed |
| cfgAddr | output | 32 | Translated configuration address with enable bit |
| readFill | output | 32 | All-ones fill data for an erroneous read |
| cfgWrEn | output | 1 | Forward the write to the configuration cycle |
| cfgRdEn | output | 1 | Forward the read to the configuration cycle |
| statusClr | output | 1 | Clear received-abort status bits |

## Verification
Two functions can fall in the same cycle: the capture of a new request, and the presentation of the previous request's result. This is provoked by driving requests on consecutive cycles. The stream mixes good, type-1 and empty-select accesses, so that an error response directly follows a good one and the reverse. The bench sets up the next request in the same half-cycle in which it checks the current outputs. It judges every output against a model of the request from the cycle before. A stale error flag, a status-clear strobe that leaks over, or a fill value carried over would each show as a mismatch.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;
  typedef struct packed {
    logic capture;
    logic isRead;
  } ctlStrobes_t;
endpackage

// File: rtl/cfgx_datapath.sv
module cfgx_datapath
  import cfgx_pkg::*;
#(
  parameter int OFF_W  = 16,
  parameter int BUS_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  ctlStrobes_t                 strb,
  input  logic [OFF_W-1:0]            cpuOffset,
  input  logic [2*OFF_W-1:0]          mapCfg,
  input  logic [$clog2(DATA_W/8)-1:0] sizeCode,
  input  logic [BUS_W-1:0]            busNum,
  output logic                        xlateErr,
  output logic                        respErr,
  output logic [31:0]                 cfgAddr,
  output logic [DATA_W-1:0]           readFill
);
  localparam int IDSEL_LSB = 11;
  localparam int IDSEL_W   = 2*OFF_W - IDSEL_LSB;
  localparam int DEV_W     = $clog2(IDSEL_W);
  localparam int LANES     = DATA_W/8;
  localparam int SZ_W      = $clog2(LANES);
  localparam int BUS_POS   = 16;

  logic [2*OFF_W-1:0] composed;
  logic [IDSEL_W-1:0] idsel;
  logic [DEV_W-1:0]   devNum;
  logic [31:0]        nextAddr;
  logic [DATA_W-1:0]  fillComb;
  logic               unusedBits;

  assign composed   = {mapCfg[OFF_W-1:0], cpuOffset};
  assign idsel      = composed[2*OFF_W-1:IDSEL_LSB];
  assign unusedBits = ^{mapCfg[2*OFF_W-1:OFF_W+1], composed[1:0]};

  // lowest set select bit wins: scan from the top so the last hit is the lowest
  always_comb begin
    devNum = '0;
    for (int i = IDSEL_W-1; i >= 0; i--) begin
      if (idsel[i]) devNum = DEV_W'(i);
    end
  end

  assign xlateErr = mapCfg[OFF_W] | ~|idsel;

  assign nextAddr = 32'h8000_0000
                  | (32'(busNum) << BUS_POS)
                  | (32'(devNum) << IDSEL_LSB)
                  | (32'(composed[10:8]) << 8)
                  | (32'(composed[7:2]) << 2);

  genvar b;
  generate
    for (b = 0; b < LANES; b++) begin : g_lane
      assign fillComb[b*8 +: 8] = {8{(SZ_W+1)'(b) <= {1'b0, sizeCode}}};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respErr  <= 1'b0;
      cfgAddr  <= '0;
      readFill <= '0;
    end else if (strb.capture) begin
      respErr  <= xlateErr;
      cfgAddr  <= xlateErr ? 32'h0 : nextAddr;
      readFill <= (xlateErr && strb.isRead) ? fillComb : '0;
    end else begin
      respErr  <= 1'b0;
      cfgAddr  <= '0;
      readFill <= '0;
    end
  end

  AST_ERR_NO_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    respErr |-> cfgAddr == 32'h0); // R4
  AST_FILL_LOW_LANE: assert property (@(posedge clk) disable iff (!rstN)
    readFill != '0 |-> readFill[7:0] == 8'hFF && respErr); // R6
  AST_ADDR_LOW_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    cfgAddr[1:0] == 2'b00); // R2
endmodule

// File: rtl/cfgx_control.sv
module cfgx_control
  import cfgx_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic        xlateErr,
  output ctlStrobes_t strb,
  output logic        respValid,
  output logic        cfgWrEn,
  output logic        cfgRdEn,
  output logic        statusClr
);
  logic goodReq;

  assign strb.capture = reqValid;
  assign strb.isRead  = ~reqWrite;
  assign goodReq      = reqValid & ~xlateErr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respValid <= 1'b0;
      cfgWrEn   <= 1'b0;
      cfgRdEn   <= 1'b0;
      statusClr <= 1'b0;
    end else begin
      respValid <= reqValid;
      cfgWrEn   <= goodReq & reqWrite;
      cfgRdEn   <= goodReq & ~reqWrite;
      statusClr <= goodReq;
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> respValid); // R10
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !respValid && !statusClr); // R10
  AST_CLR_WITH_RESP: assert property (@(posedge clk) disable iff (!rstN)
    statusClr |-> respValid); // R9
  AST_WR_RD_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(cfgWrEn && cfgRdEn)); // R8
endmodule

// File: rtl/cfgx_translator.sv
module cfgx_translator
  import cfgx_pkg::*;
#(
  parameter int OFF_W  = 16,
  parameter int BUS_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        reqValid,
  input  logic                        reqWrite,
  input  logic [OFF_W-1:0]            cpuOffset,
  input  logic [2*OFF_W-1:0]          mapCfg,
  input  logic [$clog2(DATA_W/8)-1:0] sizeCode,
  input  logic [BUS_W-1:0]            busNum,
  output logic                        respValid,
  output logic                        respErr,
  output logic [31:0]                 cfgAddr,
  output logic [DATA_W-1:0]           readFill,
  output logic                        cfgWrEn,
  output logic                        cfgRdEn,
  output logic                        statusClr
);
  ctlStrobes_t strb;
  logic        xlateErr;

  cfgx_control i_control (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqWrite  (reqWrite),
    .xlateErr  (xlateErr),
    .strb      (strb),
    .respValid (respValid),
    .cfgWrEn   (cfgWrEn),
    .cfgRdEn   (cfgRdEn),
    .statusClr (statusClr)
  );

  cfgx_datapath #(.OFF_W(OFF_W), .BUS_W(BUS_W), .DATA_W(DATA_W)) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .cpuOffset (cpuOffset),
    .mapCfg    (mapCfg),
    .sizeCode  (sizeCode),
    .busNum    (busNum),
    .xlateErr  (xlateErr),
    .respErr   (respErr),
    .cfgAddr   (cfgAddr),
    .readFill  (readFill)
  );

  AST_TYPE1_ERR: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && mapCfg[OFF_W] |=> respErr); // R4
  AST_ERR_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    respErr |-> !cfgWrEn && !cfgRdEn && !statusClr); // R7
  AST_OK_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    respValid && !respErr |-> cfgAddr[31]); // R3
  AST_ERR_ONLY_VALID: assert property (@(posedge clk) disable iff (!rstN)
    respErr |-> respValid); // R10
endmodule

// File: tb/test_cfgx_translator.sv
module test_cfgx_translator;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [15:0] cpuOffset = '0;
  logic [31:0] mapCfg = '0;
  logic [1:0]  sizeCode = '0;
  logic [7:0]  busNum = '0;
  logic        respValid, respErr, cfgWrEn, cfgRdEn, statusClr;
  logic [31:0] cfgAddr, readFill;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic        eValid = 0, eErr = 0, eWr = 0, eRd = 0, eClr = 0;
  logic [31:0] eAddr = '0, eFill = '0;
  string       eErrTag = "R4";

  always #5 clk = ~clk;

  cfgx_translator i_cfgx_translator (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .cpuOffset(cpuOffset), .mapCfg(mapCfg), .sizeCode(sizeCode), .busNum(busNum),
    .respValid(respValid), .respErr(respErr), .cfgAddr(cfgAddr),
    .readFill(readFill), .cfgWrEn(cfgWrEn), .cfgRdEn(cfgRdEn), .statusClr(statusClr)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic checkAll();
    chk("R10 respValid", 32'(respValid), 32'(eValid));
    chk({eErrTag, " respErr"}, 32'(respErr), 32'(eErr));
    chk("R1 R2 R3 cfgAddr", cfgAddr, eAddr);
    chk("R6 readFill", readFill, eFill);
    chk("R7 R8 cfgWrEn", 32'(cfgWrEn), 32'(eWr));
    chk("R8 cfgRdEn", 32'(cfgRdEn), 32'(eRd));
    chk("R9 statusClr", 32'(statusClr), 32'(eClr));
  endtask

  // model of the requirements for one request
  task automatic model(logic v, logic w, logic [15:0] off, logic [31:0] map,
                       logic [1:0] sz, logic [7:0] bus);
    logic [20:0] sel;
    int dev;
    logic err;
    sel = {map[15:0], off[15:11]};
    dev = -1;
    for (int i = 0; i < 21; i++) if (sel[i] && dev < 0) dev = i;
    err = map[16] || (sel == 0);
    eErrTag = map[16] ? "R4" : "R5";
    eValid = v;
    eErr = v && err;
    eAddr = (v && !err) ? ({1'b1, 7'b0, bus, 16'h0} | (dev << 11) |
                           ({29'b0, off[10:8]} << 8) | {24'b0, off[7:2], 2'b00}) : 32'h0;
    eFill = '0;
    if (v && err && !w) for (int b = 0; b <= int'(sz); b++) eFill[b*8 +: 8] = 8'hFF;
    eWr = v && !err && w;
    eRd = v && !err && !w;
    eClr = v && !err;
  endtask

  task automatic step(logic v, logic w, logic [15:0] off, logic [31:0] map,
                      logic [1:0] sz, logic [7:0] bus);
    @(negedge clk);
    checkAll();
    reqValid = v; reqWrite = w; cpuOffset = off; mapCfg = map;
    sizeCode = sz; busNum = bus;
    model(v, w, off, map, sz, bus);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    // R11: outputs during reset
    repeat (2) @(negedge clk);
    checkAll();
    rstN = 1'b1;
    // R1: lowest select bit at cpuOffset[11] -> device 0
    step(1, 0, 16'h0F_FC | 16'h0800, 32'h0, 2'd3, 8'h01);
    // R1: only mapCfg[15] -> device 20; high map bits ignored (R4)
    step(1, 1, 16'h07A4, 32'hFFFE_8000, 2'd0, 8'hA5);
    // R1: several bits set, lowest wins (offset bit 13 -> device 2)
    step(1, 0, 16'hE3_5C, 32'h0000_0011, 2'd1, 8'h00);
    // R2: function and register offset pass, low two bits dropped
    step(1, 1, 16'h1703, 32'h0, 2'd2, 8'hFF);
    // R5: empty select, reads at each size (R6)
    for (int s = 0; s < 4; s++) step(1, 0, 16'h07FF, 32'h0, 2'(s), 8'h3);
    // R7: empty-select write dropped
    step(1, 1, 16'h0000, 32'h0, 2'd3, 8'h3);
    // R4: type-1 bit with a valid select, read and write
    step(1, 0, 16'h0800, 32'h0001_0000, 2'd1, 8'h7);
    step(1, 1, 16'h0800, 32'h0001_0004, 2'd3, 8'h7);
    // R10: idle gap, then good after error back-to-back
    step(0, 0, 16'h0800, 32'h0, 2'd0, 8'h0);
    step(1, 0, 16'h0000, 32'h0, 2'd2, 8'h0);
    step(1, 1, 16'h1000, 32'h0, 2'd2, 8'h9);
    step(1, 0, 16'h0000, 32'h0, 2'd0, 8'h9);
    // random stream, mostly back-to-back
    for (int n = 0; n < 400; n++) begin
      logic [31:0] map;
      logic [15:0] off;
      int k;
      k = $urandom_range(0, 9);
      off = 16'($urandom);
      map = $urandom;
      if (k < 6) begin
        map[16] = 1'b0;
        map[15:0] = 16'h0;
        if (k < 3) off[15:11] = 5'h0;
        if (k < 3) map[$urandom_range(0, 15)] = 1'b1;
      end else if (k < 8) begin
        map[16:0] = 17'h0;
        off[15:11] = 5'h0;
      end else begin
        map[16] = 1'b1;
      end
      step(($urandom_range(0, 4) != 0), 1'($urandom), off, map,
           2'($urandom), 8'($urandom));
    end
    step(0, 0, 16'h0, 32'h0, 2'd0, 8'h0);
    step(0, 0, 16'h0, 32'h0, 2'd0, 8'h0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule